// File: doc/BRIEF.md
# Interrupt-Enable and Resume Flag Controller

This block owns two bits of a processor status word: the maskable-interrupt enable flag and the breakpoint resume flag. Decoded control requests come in on single-cycle strobes: enable, disable, a full flags load, and interrupt dispatch with a gate kind. The block decides which of these may change the flags and in what order they apply. An enable or disable request is legal only when the current privilege level is at least as privileged as the I/O privilege level. An illegal request leaves the flag as it was and raises a protection fault pulse.

The block also gates events that depend on the two flags. An external maskable interrupt is accepted at an instruction boundary only while the enable flag is 1. An instruction-breakpoint match raises a debug exception only while the resume flag is 0. The resume flag clears itself after one clean instruction boundary, so the same breakpoint cannot fire in an endless loop. The block also reports whether a dispatch pushes an error code; an interrupt that arrives through the external pin never pushes one.

Top module: `intf_flag_ctrl`

## Requirements
- R1: After synchronous reset, `ieFlag`, `rfFlag`, `gpFault`, `irqAccept`, `errCodeValid` and `dbgExc` are all 0.
- R2: When `curPriv` <= `ioPriv` (numerically; privilege levels are 2-bit, 0 most privileged), `setEnReq` alone sets `ieFlag` one cycle later, and `clrEnReq` clears it. If both are asserted, the flag is cleared.
- R3: When `curPriv` > `ioPriv`, a `setEnReq` or `clrEnReq` leaves `ieFlag` unchanged and produces `gpFault` = 1 for the following cycle. Without such a request, `gpFault` is 0.
- R4: `flagLoadReq` writes `loadIeVal` into `ieFlag` and `loadRfVal` into `rfFlag`, visible one cycle later.
- R5: `dispatchReq` with `dispatchTrap` = 0 (interrupt gate) clears `ieFlag`. With `dispatchTrap` = 1 (trap gate), dispatch alone leaves it unchanged.
- R6: When requests coincide, the enable flag update is chosen in this order: interrupt-gate dispatch clear, then flags load, then a legal set or clear. A protection fault still blocks the set or clear.
- R7: `errCodeValid` is 1 in the cycle after a `dispatchReq` with `dispatchErr` = 1 and `dispatchFromPin` = 0. It is 0 after any dispatch with `dispatchFromPin` = 1.
- R8: `irqAccept` is 1 in the cycle after a cycle in which `instrBoundary`, `extIrq` and `ieFlag` are all 1. Otherwise it is 0.
- R9: `dbgExc` is 1 in the cycle after `bkptHit` = 1 while `rfFlag` = 0. A match while `rfFlag` = 1 gives no debug exception.
- R10: Without a flags load, `rfFlag` clears after an `instrBoundary` cycle in which no breakpoint match was suppressed. It stays set across a boundary with a suppressed match. A flags load in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| curPriv | input | 2 | Current privilege level |
| ioPriv | input | 2 | I/O privilege level |
| setEnReq | input | 1 | Request to set the enable flag |
| clrEnReq | input | 1 | Request to clear the enable flag |
| flagLoadReq | input | 1 | Full flags load (pop, return, task switch) |
| loadIeVal | input | 1 | Enable flag value carried by the load |
| loadRfVal | input | 1 | Resume flag value carried by the load |
| dispatchReq | input | 1 | Interrupt or exception dispatch |
| dispatchTrap | input | 1 | 1 = trap gate, 0 = interrupt gate |
| dispatchErr | input | 1 | The dispatched vector normally carries an error code |
| dispatchFromPin | input | 1 | The dispatch comes from the external maskable pin |
| extIrq | input | 1 | External maskable interrupt request |
| instrBoundary | input | 1 | Instruction boundary strobe |
| bkptHit | input | 1 | Instruction-breakpoint match |
| ieFlag | output | 1 | Interrupt enable flag |
| rfFlag | output | 1 | Resume flag |
| gpFault | output | 1 | Protection fault pulse |
| irqAccept | output | 1 | External interrupt accepted pulse |
| errCodeValid | output | 1 | Dispatch pushes an error code |
| dbgExc | output | 1 | Debug exception pulse |

## Verification
Enable and disable requests are swept over all 16 pairs of current and I/O privilege, from both starting flag values and with set, clear and both together. This separates a legal write, a faulting attempt and the clear-wins rule. Dispatch, load and set are tried in every combination with each gate kind and error-code source. This shows the update order and which dispatches push an error code. Interrupt acceptance and breakpoint handling are swept over every flag, request and boundary combination, with and without a coinciding load. A final sequence shows the resume flag surviving a suppressed match and then clearing at the next clean boundary.

// File: rtl/intf_flag_pkg.sv
package intf_flag_pkg;
  typedef struct packed {
    logic ieWrite;
    logic ieVal;
    logic rfWrite;
    logic rfVal;
    logic fault;
    logic accept;
    logic debug;
    logic errCode;
  } flagStrobe_t;
endpackage

// File: rtl/intf_flag_ctl.sv
module intf_flag_ctl
  import intf_flag_pkg::*;
#(
  parameter int PRIV_W   = 2,
  parameter bit CLR_WINS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PRIV_W-1:0] curPriv,
  input  logic [PRIV_W-1:0] ioPriv,
  input  logic              setEnReq,
  input  logic              clrEnReq,
  input  logic              flagLoadReq,
  input  logic              loadIeVal,
  input  logic              loadRfVal,
  input  logic              dispatchReq,
  input  logic              dispatchTrap,
  input  logic              dispatchErr,
  input  logic              dispatchFromPin,
  input  logic              extIrq,
  input  logic              instrBoundary,
  input  logic              bkptHit,
  input  logic              ieFlag,
  input  logic              rfFlag,
  output flagStrobe_t       strobe
);
  logic privOk;
  logic editReq;
  logic editVal;
  logic intGateClr;
  logic suppressed;

  assign privOk     = (curPriv <= ioPriv);
  assign editReq    = setEnReq | clrEnReq;
  assign intGateClr = dispatchReq & ~dispatchTrap;
  assign suppressed = bkptHit & rfFlag;

  generate
    if (CLR_WINS) begin : g_clrWins
      assign editVal = setEnReq & ~clrEnReq;
    end else begin : g_setWins
      assign editVal = setEnReq;
    end
  endgenerate

  always_comb begin
    strobe = '0;
    strobe.fault = editReq & ~privOk;
    if (intGateClr) begin
      strobe.ieWrite = 1'b1;
      strobe.ieVal   = 1'b0;
    end else if (flagLoadReq) begin
      strobe.ieWrite = 1'b1;
      strobe.ieVal   = loadIeVal;
    end else if (editReq && privOk) begin
      strobe.ieWrite = 1'b1;
      strobe.ieVal   = editVal;
    end
    if (flagLoadReq) begin
      strobe.rfWrite = 1'b1;
      strobe.rfVal   = loadRfVal;
    end else if (instrBoundary && !suppressed) begin
      strobe.rfWrite = 1'b1;
      strobe.rfVal   = 1'b0;
    end
    strobe.accept  = instrBoundary & extIrq & ieFlag;
    strobe.debug   = bkptHit & ~rfFlag;
    strobe.errCode = dispatchReq & dispatchErr & ~dispatchFromPin;
  end

  // R3
  priv_block_chk: assert property (@(posedge clk) disable iff (rst)
    (editReq && !privOk && !dispatchReq && !flagLoadReq) |=> (ieFlag == $past(ieFlag)));

  // R2
  set_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (setEnReq && !clrEnReq && privOk && !dispatchReq && !flagLoadReq) |=> ieFlag);

  // R5
  int_gate_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (dispatchReq && !dispatchTrap) |=> !ieFlag);
endmodule

// File: rtl/intf_flag_dp.sv
module intf_flag_dp
  import intf_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  flagStrobe_t strobe,
  output logic        ieFlag,
  output logic        rfFlag,
  output logic        gpFault,
  output logic        irqAccept,
  output logic        errCodeValid,
  output logic        dbgExc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ieFlag       <= 1'b0;
      rfFlag       <= 1'b0;
      gpFault      <= 1'b0;
      irqAccept    <= 1'b0;
      errCodeValid <= 1'b0;
      dbgExc       <= 1'b0;
    end else begin
      if (strobe.ieWrite) ieFlag <= strobe.ieVal;
      if (strobe.rfWrite) rfFlag <= strobe.rfVal;
      gpFault      <= strobe.fault;
      irqAccept    <= strobe.accept;
      errCodeValid <= strobe.errCode;
      dbgExc       <= strobe.debug;
    end
  end

  // R10
  rf_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rfFlag) |-> $past(strobe.rfWrite && strobe.rfVal));
endmodule

// File: rtl/intf_flag_ctrl.sv
module intf_flag_ctrl
  import intf_flag_pkg::*;
#(
  parameter int PRIV_W   = 2,
  parameter bit CLR_WINS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PRIV_W-1:0] curPriv,
  input  logic [PRIV_W-1:0] ioPriv,
  input  logic              setEnReq,
  input  logic              clrEnReq,
  input  logic              flagLoadReq,
  input  logic              loadIeVal,
  input  logic              loadRfVal,
  input  logic              dispatchReq,
  input  logic              dispatchTrap,
  input  logic              dispatchErr,
  input  logic              dispatchFromPin,
  input  logic              extIrq,
  input  logic              instrBoundary,
  input  logic              bkptHit,
  output logic              ieFlag,
  output logic              rfFlag,
  output logic              gpFault,
  output logic              irqAccept,
  output logic              errCodeValid,
  output logic              dbgExc
);
  flagStrobe_t strobe;

  intf_flag_ctl #(.PRIV_W(PRIV_W), .CLR_WINS(CLR_WINS)) u_ctl (
    .clk(clk), .rst(rst), .curPriv(curPriv), .ioPriv(ioPriv),
    .setEnReq(setEnReq), .clrEnReq(clrEnReq), .flagLoadReq(flagLoadReq),
    .loadIeVal(loadIeVal), .loadRfVal(loadRfVal), .dispatchReq(dispatchReq),
    .dispatchTrap(dispatchTrap), .dispatchErr(dispatchErr),
    .dispatchFromPin(dispatchFromPin), .extIrq(extIrq),
    .instrBoundary(instrBoundary), .bkptHit(bkptHit),
    .ieFlag(ieFlag), .rfFlag(rfFlag), .strobe(strobe)
  );

  intf_flag_dp u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .ieFlag(ieFlag), .rfFlag(rfFlag), .gpFault(gpFault),
    .irqAccept(irqAccept), .errCodeValid(errCodeValid), .dbgExc(dbgExc)
  );

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (instrBoundary && extIrq && !ieFlag) |=> !irqAccept);

  // R9
  bkpt_suppress_chk: assert property (@(posedge clk) disable iff (rst)
    (bkptHit && rfFlag) |=> !dbgExc);

  // R7
  pin_no_errcode_chk: assert property (@(posedge clk) disable iff (rst)
    (dispatchReq && dispatchFromPin) |=> !errCodeValid);
endmodule

// File: tb/intf_flag_ctrl_tb.sv
module intf_flag_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] curPriv = '0, ioPriv = '0;
  logic setEnReq = 0, clrEnReq = 0, flagLoadReq = 0, loadIeVal = 0, loadRfVal = 0;
  logic dispatchReq = 0, dispatchTrap = 0, dispatchErr = 0, dispatchFromPin = 0;
  logic extIrq = 0, instrBoundary = 0, bkptHit = 0;
  logic ieFlag, rfFlag, gpFault, irqAccept, errCodeValid, dbgExc;

  int nTests = 0;
  int nFail  = 0;
  bit eIe = 0, eRf = 0;
  string ieTag = "R2";
  string rfTag = "R10";

  always #5 clk = ~clk;

  intf_flag_ctrl u_dut (
    .clk(clk), .rst(rst), .curPriv(curPriv), .ioPriv(ioPriv),
    .setEnReq(setEnReq), .clrEnReq(clrEnReq), .flagLoadReq(flagLoadReq),
    .loadIeVal(loadIeVal), .loadRfVal(loadRfVal), .dispatchReq(dispatchReq),
    .dispatchTrap(dispatchTrap), .dispatchErr(dispatchErr),
    .dispatchFromPin(dispatchFromPin), .extIrq(extIrq),
    .instrBoundary(instrBoundary), .bkptHit(bkptHit),
    .ieFlag(ieFlag), .rfFlag(rfFlag), .gpFault(gpFault), .irqAccept(irqAccept),
    .errCodeValid(errCodeValid), .dbgExc(dbgExc)
  );

  task automatic chk(input string req, input string name, input bit act, input bit exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s act=%0b exp=%0b at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic clearIn();
    setEnReq = 0; clrEnReq = 0; flagLoadReq = 0; loadIeVal = 0; loadRfVal = 0;
    dispatchReq = 0; dispatchTrap = 0; dispatchErr = 0; dispatchFromPin = 0;
    extIrq = 0; instrBoundary = 0; bkptHit = 0;
  endtask

  // Advance one cycle with the inputs already driven; predict from requirements.
  task automatic cycle();
    bit fault, nIe, nRf, acc, dbg, err;
    fault = (setEnReq | clrEnReq) && (curPriv > ioPriv);
    nIe = eIe;
    if (dispatchReq && !dispatchTrap) nIe = 0;
    else if (flagLoadReq) nIe = loadIeVal;
    else if (!fault && clrEnReq) nIe = 0;
    else if (!fault && setEnReq) nIe = 1;
    nRf = eRf;
    if (flagLoadReq) nRf = loadRfVal;
    else if (instrBoundary && !(bkptHit && eRf)) nRf = 0;
    acc = instrBoundary && extIrq && eIe;
    dbg = bkptHit && !eRf;
    err = dispatchReq && dispatchErr && !dispatchFromPin;
    @(posedge clk);
    #1;
    eIe = nIe; eRf = nRf;
    chk(ieTag, "ieFlag", ieFlag, eIe);
    chk(rfTag, "rfFlag", rfFlag, eRf);
    chk("R3", "gpFault", gpFault, fault);
    chk("R8", "irqAccept", irqAccept, acc);
    chk("R9", "dbgExc", dbgExc, dbg);
    chk("R7", "errCodeValid", errCodeValid, err);
    clearIn();
  endtask

  task automatic setFlags(input bit ie, input bit rf);
    @(negedge clk);
    flagLoadReq = 1; loadIeVal = ie; loadRfVal = rf;
    cycle();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R1: reset state
    chk("R1", "ieFlag", ieFlag, 0);
    chk("R1", "rfFlag", rfFlag, 0);
    chk("R1", "gpFault", gpFault, 0);
    chk("R1", "irqAccept", irqAccept, 0);
    chk("R1", "errCodeValid", errCodeValid, 0);
    chk("R1", "dbgExc", dbgExc, 0);

    // R2 / R3: privilege sweep
    ieTag = "R3"; rfTag = "R4";
    for (int ie0 = 0; ie0 < 2; ie0++)
      for (int c = 0; c < 4; c++)
        for (int io = 0; io < 4; io++)
          for (int op = 0; op < 3; op++) begin
            setFlags(ie0[0], 1'b0);
            @(negedge clk);
            curPriv = c[1:0]; ioPriv = io[1:0];
            setEnReq = (op != 1); clrEnReq = (op != 0);
            ieTag = (c <= io) ? "R2" : "R3";
            cycle();
            ieTag = "R3";
          end

    // R5 / R6 / R7 / R4: dispatch, load and set in every combination
    curPriv = 0; ioPriv = 3;
    for (int v = 0; v < 256; v++) begin
      setFlags(v[0], 1'b0);
      @(negedge clk);
      dispatchReq = v[1]; dispatchTrap = v[2]; flagLoadReq = v[3];
      loadIeVal = v[4]; setEnReq = v[5]; dispatchErr = v[6]; dispatchFromPin = v[7];
      loadRfVal = v[4];
      ieTag = (v[1] && (v[3] || v[5])) ? "R6" : (v[1] ? "R5" : "R4");
      rfTag = "R4";
      cycle();
    end

    // R5: faulting set coinciding with a trap-gate dispatch
    curPriv = 3; ioPriv = 0;
    setFlags(1'b0, 1'b0);
    @(negedge clk);
    dispatchReq = 1; dispatchTrap = 1; setEnReq = 1;
    ieTag = "R6";
    cycle();

    // R8: interrupt acceptance sweep
    curPriv = 0; ioPriv = 0;
    ieTag = "R4"; rfTag = "R10";
    for (int v = 0; v < 8; v++) begin
      setFlags(v[0], 1'b0);
      @(negedge clk);
      extIrq = v[1]; instrBoundary = v[2];
      cycle();
    end

    // R9 / R10: breakpoint and resume sweep
    for (int v = 0; v < 32; v++) begin
      setFlags(1'b0, v[0]);
      @(negedge clk);
      bkptHit = v[1]; instrBoundary = v[2]; flagLoadReq = v[3]; loadRfVal = v[4];
      rfTag = v[3] ? "R4" : "R10";
      cycle();
    end

    // R10: suppressed match keeps the flag, next clean boundary clears it
    rfTag = "R10";
    setFlags(1'b0, 1'b1);
    @(negedge clk); bkptHit = 1; instrBoundary = 1; cycle();
    @(negedge clk); bkptHit = 1; cycle();
    @(negedge clk); instrBoundary = 1; cycle();
    @(negedge clk); bkptHit = 1; cycle();

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule